// File: doc/BRIEF.md
# Selectable CAN Clock Enable Generator

This block turns two free-running reference tick streams into the single clock-enable stream that paces a CAN protocol controller. One reference ticks at 240 MHz and the other at 80 MHz. A 4-bit select word picks the source and, for the fast source, an integer divider. The enable pulses then run at 80, 60, 40, 30, 24 or 20 MHz. The block also reports the resulting frequency in MHz, so software can read back the bit timing base that is actually in use.

A select word outside the legal set is not kept. It is replaced by the plain slow-source code, and that code is what reads back.

The block also carries a per-channel timestamp counter. The counter advances once per output enable pulse. A one-bit hold control keeps it at zero while the bit is set. Software uses the hold bit around a mode change to restart channel time from zero.

Top module: `can_ce_gen`

## Requirements
- R1: After a synchronous reset, the select readback is 0x0, the frequency readback is 80, `can_ce` is low, the timestamp hold bit is clear and the timestamp is 0.
- R2: With select bit 3 set, divider codes 0, 1, 2, 3 and 4 in bits 2:0 produce one `can_ce` pulse every 4, 6, 8, 10 and 12 fast ticks. The frequency readback is then 60, 40, 30, 24 and 20.
- R3: With select bit 3 clear, `can_ce` copies `ref_slow_tick` with one register of delay, bits 2:0 have no effect, and the frequency readback is 80.
- R4: A write of 0xD, 0xE or 0xF (bit 3 set with a divider code above 4) stores 0x0 and runs the slow source.
- R5: Any legal write is stored as written, and `sel_rd` returns the stored value from the cycle after the write.
- R6: When a write changes the stored selection, the divider restarts. `can_ce` is low in the cycle after the write edge. With a fast tick on every cycle, the first fast pulse comes N+1 cycles after the write edge, where N is the ratio.
- R7: While the timestamp hold bit (bit 0 of the misc write) is set, the timestamp reads 0, starting two cycles after the write edge.
- R8: While the hold bit is clear, the timestamp increments by exactly one in the cycle after each `can_ce` pulse and holds otherwise.
- R9: `freq_mhz` always matches the stored selection: 80 for the slow source, otherwise 240 divided by the ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_fast_tick | input | 1 | One-cycle tick of the 240 MHz reference |
| ref_slow_tick | input | 1 | One-cycle tick of the 80 MHz reference |
| sel_wr_en | input | 1 | Write strobe for the select word |
| sel_wr_data | input | 4 | Select word: bit 3 source, bits 2:0 divider code |
| misc_wr_en | input | 1 | Write strobe for the timestamp hold bit |
| misc_wr_data | input | 1 | Timestamp hold bit value (misc bit 0) |
| sel_rd | output | 4 | Select word in effect |
| freq_mhz | output | 8 | Resulting enable frequency in MHz |
| can_ce | output | 1 | Clock-enable pulse to the CAN controller |
| ts_hold | output | 1 | Timestamp hold bit in effect |
| ts_value | output | 32 | Channel timestamp count |

## Verification
Faults in the divider counter appear at `can_ce` within one ratio period (at most 13 cycles after a write) as a pulse that is early, late or doubled. Faults in the select decode appear on `sel_rd` and `freq_mhz` in the very next cycle. The bench writes all sixteen select codes in sequence and predicts every enable cycle arithmetically from the ratio and the slow tick pattern. A corrupted timestamp path shows up as a count that differs from the bench's own tally of pulses. That difference is visible one cycle after the offending pulse or hold change.

// File: rtl/ccg_pkg.sv
package ccg_pkg;
  localparam int SEL_W     = 4;
  localparam int SRC_BIT   = 3;
  localparam int DIV_W     = 3;
  localparam int MAX_CODE  = 4;
  localparam int BASE_RAT  = 4;
  localparam int STEP_RAT  = 2;
  localparam int MAX_RATIO = BASE_RAT + STEP_RAT * MAX_CODE;
  localparam int RATIO_W   = $clog2(MAX_RATIO + 1);
  localparam int FAST_MHZ  = 240;
  localparam int SLOW_MHZ  = 80;
  localparam int FREQ_W    = 8;

  // legal: slow source with any field, or fast source with code <= MAX_CODE
  function automatic logic code_ok(logic [SEL_W-1:0] s);
    return !s[SRC_BIT] || (int'(s[DIV_W-1:0]) <= MAX_CODE);
  endfunction

  function automatic logic [RATIO_W-1:0] ratio_of(logic [DIV_W-1:0] d);
    return RATIO_W'(BASE_RAT + STEP_RAT * int'(d));
  endfunction

  function automatic logic [FREQ_W-1:0] freq_of(logic [SEL_W-1:0] s);
    if (!s[SRC_BIT]) return FREQ_W'(SLOW_MHZ);
    return FREQ_W'(FAST_MHZ / (BASE_RAT + STEP_RAT * int'(s[DIV_W-1:0])));
  endfunction
endpackage

// File: rtl/ccg_sel_reg.sv
module ccg_sel_reg
  import ccg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_data,
  output logic [SEL_W-1:0]  sel_q,
  output logic              chg_q,
  output logic [FREQ_W-1:0] freq_q
);
  logic [SEL_W-1:0] eff;

  // illegal codes collapse to the slow-source code
  always_comb eff = code_ok(wr_data) ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      chg_q  <= 1'b0;
      freq_q <= FREQ_W'(SLOW_MHZ);
    end else begin
      chg_q <= 1'b0;
      if (wr_en) begin
        sel_q  <= eff;
        chg_q  <= (eff != sel_q);
        freq_q <= freq_of(eff);
      end
    end
  end
endmodule

// File: rtl/ccg_divider.sv
module ccg_divider
  import ccg_pkg::*;
#(
  parameter int CNT_W = RATIO_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fast_src,
  input  logic [CNT_W-1:0] ratio,
  input  logic             restart,
  input  logic             fast_tick,
  input  logic             slow_tick,
  output logic             ce_q
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  always_comb last = ratio - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt  <= '0;
      ce_q <= 1'b0;
    end else if (fast_src) begin
      if (fast_tick) begin
        if (cnt == last) begin
          cnt  <= '0;
          ce_q <= 1'b1;
        end else begin
          cnt  <= cnt + CNT_W'(1);
          ce_q <= 1'b0;
        end
      end else begin
        ce_q <= 1'b0;
      end
    end else begin
      cnt  <= '0;
      ce_q <= slow_tick;
    end
  end
endmodule

// File: rtl/ccg_tstamp.sv
module ccg_tstamp #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold_wr_en,
  input  logic            hold_wr_data,
  input  logic            ce,
  output logic            hold_q,
  output logic [TS_W-1:0] count_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= 1'b0;
      count_q <= '0;
    end else begin
      if (hold_wr_en) hold_q <= hold_wr_data;
      if (hold_q)     count_q <= '0;
      else if (ce)    count_q <= count_q + TS_W'(1);
    end
  end
endmodule

// File: rtl/can_ce_gen.sv
module can_ce_gen
  import ccg_pkg::*;
#(
  parameter int TS_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_fast_tick,
  input  logic              ref_slow_tick,
  input  logic              sel_wr_en,
  input  logic [SEL_W-1:0]  sel_wr_data,
  input  logic              misc_wr_en,
  input  logic              misc_wr_data,
  output logic [SEL_W-1:0]  sel_rd,
  output logic [FREQ_W-1:0] freq_mhz,
  output logic              can_ce,
  output logic              ts_hold,
  output logic [TS_W-1:0]   ts_value
);
  logic               sel_chg;
  logic [RATIO_W-1:0] ratio;

  ccg_sel_reg u_sel (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (sel_wr_en),
    .wr_data (sel_wr_data),
    .sel_q   (sel_rd),
    .chg_q   (sel_chg),
    .freq_q  (freq_mhz)
  );

  always_comb ratio = ratio_of(sel_rd[DIV_W-1:0]);

  ccg_divider #(.CNT_W(RATIO_W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .fast_src  (sel_rd[SRC_BIT]),
    .ratio     (ratio),
    .restart   (sel_chg),
    .fast_tick (ref_fast_tick),
    .slow_tick (ref_slow_tick),
    .ce_q      (can_ce)
  );

  ccg_tstamp #(.TS_W(TS_W)) u_ts (
    .clk          (clk),
    .rst          (rst),
    .hold_wr_en   (misc_wr_en),
    .hold_wr_data (misc_wr_data),
    .ce           (can_ce),
    .hold_q       (ts_hold),
    .count_q      (ts_value)
  );
endmodule

// File: rtl/ccg_checker.sv
module ccg_checker
  import ccg_pkg::*;
#(
  parameter int TS_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [SEL_W-1:0]  sel_rd,
  input logic [FREQ_W-1:0] freq_mhz,
  input logic              can_ce,
  input logic              ts_hold,
  input logic [TS_W-1:0]   ts_value
);
  assert_sel_legal_R4: assert property (@(posedge clk) disable iff (rst)
    sel_rd[SRC_BIT] |-> (sel_rd[DIV_W-1:0] <= DIV_W'(MAX_CODE)));

  assert_slow_freq_R3: assert property (@(posedge clk) disable iff (rst)
    !sel_rd[SRC_BIT] |-> (freq_mhz == FREQ_W'(SLOW_MHZ)));

  assert_fast_freq_R9: assert property (@(posedge clk) disable iff (rst)
    sel_rd[SRC_BIT] |-> (freq_mhz <= FREQ_W'(60) && freq_mhz >= FREQ_W'(20)));

  assert_fast_gap_R2: assert property (@(posedge clk) disable iff (rst)
    (sel_rd[SRC_BIT] && can_ce) |=> !can_ce);

  assert_hold_clear_R7: assert property (@(posedge clk) disable iff (rst)
    ts_hold |=> (ts_value == '0));

  assert_ts_step_R8: assert property (@(posedge clk) disable iff (rst)
    (!ts_hold && can_ce) |=> (ts_value == $past(ts_value) + TS_W'(1)));

  assert_ts_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!ts_hold && !can_ce) |=> $stable(ts_value));
endmodule

bind can_ce_gen ccg_checker #(.TS_W(TS_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sel_rd   (sel_rd),
  .freq_mhz (freq_mhz),
  .can_ce   (can_ce),
  .ts_hold  (ts_hold),
  .ts_value (ts_value)
);

// File: tb/sim_can_ce_gen.sv
module sim_can_ce_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_fast_tick = 1'b0, ref_slow_tick = 1'b0;
  logic        sel_wr_en = 1'b0, misc_wr_en = 1'b0, misc_wr_data = 1'b0;
  logic [3:0]  sel_wr_data = 4'h0;
  logic [3:0]  sel_rd;
  logic [7:0]  freq_mhz;
  logic        can_ce, ts_hold;
  logic [31:0] ts_value;

  int  checks = 0, errors = 0, k = 0;
  bit  done = 0, last_slow = 0, prev_ce = 0;
  longint exp_ts = 0;

  always #5 clk = ~clk;

  can_ce_gen u0 (
    .clk(clk), .rst(rst), .ref_fast_tick(ref_fast_tick), .ref_slow_tick(ref_slow_tick),
    .sel_wr_en(sel_wr_en), .sel_wr_data(sel_wr_data), .misc_wr_en(misc_wr_en),
    .misc_wr_data(misc_wr_data), .sel_rd(sel_rd), .freq_mhz(freq_mhz), .can_ce(can_ce),
    .ts_hold(ts_hold), .ts_value(ts_value)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step();
    last_slow = (k % 3 == 0);
    ref_slow_tick = last_slow;
    k++;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ts_step(input string req);
    step();
    exp_ts += prev_ce;
    chk(ts_value == 32'(exp_ts), req, ts_value, exp_ts);
    prev_ce = can_ce;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] eff, eff_prev;
    bit ok_code, changed, exp_ce;
    int n, fexp;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(sel_rd == 4'h0, "R1 sel_rd", sel_rd, 0);
    chk(freq_mhz == 8'd80, "R1 freq", freq_mhz, 80);
    chk(can_ce == 1'b0, "R1 can_ce", can_ce, 0);
    chk(ts_hold == 1'b0, "R1 ts_hold", ts_hold, 0);
    chk(ts_value == 32'd0, "R1 ts_value", ts_value, 0);
    rst = 1'b0;
    ref_fast_tick = 1'b1;
    eff_prev = 4'h0;

    // sweep of all select codes
    for (int v = 0; v < 16; v++) begin
      ok_code = (v < 8) || ((v & 7) <= 4);
      eff = ok_code ? 4'(v) : 4'h0;
      changed = (eff != eff_prev);
      n = 4 + 2 * int'(eff[2:0]);
      fexp = eff[3] ? 240 / n : 80;
      sel_wr_en = 1'b1; sel_wr_data = 4'(v);
      step();
      sel_wr_en = 1'b0;
      chk(sel_rd == eff, ok_code ? "R5 readback" : "R4 illegal code stored as 0", sel_rd, eff);
      chk(freq_mhz == 8'(fexp), "R9 freq readback", freq_mhz, fexp);
      for (int t = 1; t <= 40; t++) begin
        step();
        if (eff[3]) begin
          exp_ce = (t > 1) && ((t - 1) % n == 0);
          chk(can_ce == exp_ce, (t <= n + 1) ? "R6 restart" : "R2 divider period", can_ce, exp_ce);
        end else begin
          exp_ce = (t == 1 && changed) ? 1'b0 : last_slow;
          chk(can_ce == exp_ce, (t == 1) ? "R6 restart" : "R3 slow pass", can_ce, exp_ce);
        end
      end
      eff_prev = eff;
    end

    // R7 hold
    misc_wr_en = 1'b1; misc_wr_data = 1'b1;
    step();
    misc_wr_en = 1'b0;
    chk(ts_hold == 1'b1, "R7 hold set", ts_hold, 1);
    for (int i = 0; i < 8; i++) begin
      step();
      chk(ts_value == 32'd0, "R7 held at zero", ts_value, 0);
    end

    // R8 counting after release, slow then fast source
    misc_wr_en = 1'b1; misc_wr_data = 1'b0;
    step();
    misc_wr_en = 1'b0;
    exp_ts = 0;
    chk(ts_value == 32'd0 && ts_hold == 1'b0, "R8 release", ts_value, 0);
    prev_ce = can_ce;
    for (int i = 0; i < 30; i++) ts_step("R8 slow count");
    sel_wr_en = 1'b1; sel_wr_data = 4'hA;
    ts_step("R8 count at write");
    sel_wr_en = 1'b0;
    for (int i = 0; i < 40; i++) ts_step("R8 fast count");
    ref_fast_tick = 1'b0;
    for (int i = 0; i < 5; i++) ts_step("R8 idle hold");

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule